// File: doc/BRIEF.md
# Checker Command and Status Register Engine

This block is the software-facing command front end of an I/O memory-protection checker. It holds four 64-bit little-endian registers, each reached as two 32-bit halves over a simple register bus: a read-only capability word, a command word, and two operand words. Software loads the operand words, then writes the low half of the command word with an opcode and a rule index. The engine then runs one operation against its neighbours. It can write a classification rule into the external rule table, read a rule back into the operand words, request an invalidation of cached protection-table data, or request a fence.

A busy flag is held from the command write until the operation ends. The engine first validates the opcode, the rule index and the operands. A rejected command ends one cycle later with an error code and makes no downstream request. An accepted command raises exactly one request toward the rule table, the invalidation port or the fence port. It holds that request until the acknowledge arrives and then posts a success code. While busy is high, writes to the command and operand words are dropped.

Top module: `ckcmd_engine`

## Requirements
- R1: After reset the busy flag (command word bit 39) and the status field (bits 38:32) read 0.
- R2: Byte offset 0 returns 0x10 in bits 7:0 and the parameter WIDE_MODES in bit 8, with all other bits 0. Writes to it have no effect.
- R3: Bus address bits 4:3 select the register (0 capability, 1 command, 2 operand-0, 3 operand-1), and bit 2 selects the high half. Operand words read back as written while idle.
- R4: A write to the low command half (byte offset 8) stores the opcode in bits 7:0 and the rule index in bits 23:8, and sets busy from the next cycle. Bits 31:24 read 0. Writes to the high command half have no effect.
- R5: An opcode other than 1 (set rule), 2 (get rule), 3 (invalidate) or 4 (fence) ends with status 2, one cycle after busy rose, and makes no downstream request.
- R6: Set rule and get rule with a rule index of 0 or above NUM_RULES end with status 3 and make no request.
- R7: Set rule with table mode 0 (operand-1 bits 3:0) ends with status 4 and no write when the domain ID (operand-0 bits 47:40) or the root page number (operand-1 bits 53:10) is nonzero.
- R8: An accepted set rule raises a rule-table write carrying the rule index and {operand-1, operand-0}, and holds it until acknowledge. Busy clears on the cycle after the acknowledge, with status 1.
- R9: An accepted get rule raises a rule-table read. On acknowledge, operand-0 takes read data bits 63:0 and operand-1 takes bits 127:64, and the command ends with status 1.
- R10: Invalidate ignores the rule index. It presents the domain ID, the domain-valid flag (operand-1 bit 6), the page number, the page-valid flag (bit 4) and the range-size flag (bit 5), and ends with status 1 on acknowledge.
- R11: Fence ignores the rule index, raises a fence request and ends with status 1 on acknowledge.
- R12: While busy, writes to the command word and the operand words are ignored.
- R13: At most one downstream request is raised at a time, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address bits 4:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rt_req | output | 1 | Rule-table request |
| rt_write | output | 1 | 1 = write rule, 0 = read rule |
| rt_idx | output | 16 | Rule index |
| rt_wdata | output | 128 | Rule record {operand-1, operand-0} |
| rt_rdata | input | 128 | Rule record returned on acknowledge |
| rt_ack | input | 1 | Rule-table acknowledge |
| inv_req | output | 1 | Invalidation request |
| inv_dom | output | 8 | Domain ID to invalidate |
| inv_dom_vld | output | 1 | Domain ID is valid |
| inv_ppn | output | 44 | Page number of the range |
| inv_ppn_vld | output | 1 | Page number is valid |
| inv_napot | output | 1 | Range is naturally aligned power of two |
| inv_ack | input | 1 | Invalidation acknowledge |
| fence_req | output | 1 | Fence request |
| fence_ack | input | 1 | Fence acknowledge |

## Verification
The bench builds the engine with NUM_RULES=5 and WIDE_MODES=1. With only five legal rule indices, both edges of the range are cheap to test: index 5 is accepted, and indices 6 and 0 are rejected. The wide-mode bit shows as a visible 1 in the capability word. The responder's acknowledge delay can be lengthened, which keeps busy high long enough to try command and operand writes in the middle of an operation. Index values 0 and 0xFFFF then show that fence and invalidate ignore the index.

// File: rtl/ckcmd_pkg.sv
package ckcmd_pkg;

    localparam int IDX_W    = 16;
    localparam int DOM_W    = 8;
    localparam int PPN_W    = 44;
    localparam int MODE_W   = 4;
    localparam int DOM_LSB  = 40;   // operand-0
    localparam int PPN_LSB  = 10;   // operand-1
    localparam int PPNV_BIT = 4;    // operand-1
    localparam int NAPOT_BIT = 5;   // operand-1
    localparam int DOMV_BIT = 6;    // operand-1
    localparam logic [7:0] VERSION = 8'h10;

    localparam logic [7:0] OPC_SET   = 8'd1;
    localparam logic [7:0] OPC_GET   = 8'd2;
    localparam logic [7:0] OPC_INVAL = 8'd3;
    localparam logic [7:0] OPC_FENCE = 8'd4;

    typedef enum logic [6:0] {
        ST_NONE    = 7'd0,
        ST_OK      = 7'd1,
        ST_BAD_OP  = 7'd2,
        ST_BAD_IDX = 7'd3,
        ST_BAD_ARG = 7'd4
    } st_e;

    typedef enum logic [2:0] {
        K_NONE, K_SET, K_GET, K_INVAL, K_FENCE
    } kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       opc;
    } cmd_t;

    typedef struct packed {
        st_e   verdict;
        kind_e kind;
    } decision_t;

endpackage

// File: rtl/ckcmd_check.sv
module ckcmd_check
    import ckcmd_pkg::*;
#(
    parameter int NUM_RULES = 8
) (
    input  cmd_t              cmd,
    input  logic [DOM_W-1:0]  dom,
    input  logic [PPN_W-1:0]  ppn,
    input  logic [MODE_W-1:0] mode,
    output decision_t         dec
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_RULES);

    logic idx_ok;
    logic bare_bad;

    assign idx_ok   = (cmd.idx != '0) && (cmd.idx <= MAX_IDX);
    assign bare_bad = (mode == '0) && ((dom != '0) || (ppn != '0));

    always_comb begin
        dec = '{verdict: ST_BAD_OP, kind: K_NONE};
        case (cmd.opc)
            OPC_SET: begin
                if (!idx_ok)       dec = '{verdict: ST_BAD_IDX, kind: K_NONE};
                else if (bare_bad) dec = '{verdict: ST_BAD_ARG, kind: K_NONE};
                else               dec = '{verdict: ST_OK,      kind: K_SET};
            end
            OPC_GET: begin
                if (!idx_ok) dec = '{verdict: ST_BAD_IDX, kind: K_NONE};
                else         dec = '{verdict: ST_OK,      kind: K_GET};
            end
            OPC_INVAL: dec = '{verdict: ST_OK, kind: K_INVAL};
            OPC_FENCE: dec = '{verdict: ST_OK, kind: K_FENCE};
            default:   dec = '{verdict: ST_BAD_OP, kind: K_NONE};
        endcase
    end
endmodule

// File: rtl/ckcmd_seq.sv
module ckcmd_seq
    import ckcmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  decision_t dec,
    input  logic      rt_ack,
    input  logic      inv_ack,
    input  logic      fence_ack,
    output logic      busy,
    output st_e       status,
    output logic      rt_req,
    output logic      rt_write,
    output logic      inv_req,
    output logic      fence_req,
    output logic      load_ops
);
    typedef enum logic [1:0] {PH_IDLE, PH_EVAL, PH_WAIT} phase_e;
    phase_e phase;
    logic   acked;

    assign acked    = (rt_req & rt_ack) | (inv_req & inv_ack) | (fence_req & fence_ack);
    assign load_ops = (phase == PH_WAIT) && rt_req && !rt_write && rt_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            busy      <= 1'b0;
            status    <= ST_NONE;
            rt_req    <= 1'b0;
            rt_write  <= 1'b0;
            inv_req   <= 1'b0;
            fence_req <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    busy  <= 1'b1;
                    phase <= PH_EVAL;
                end
                PH_EVAL: begin
                    if (dec.verdict != ST_OK) begin
                        status <= dec.verdict;
                        busy   <= 1'b0;
                        phase  <= PH_IDLE;
                    end else begin
                        rt_req    <= (dec.kind == K_SET) || (dec.kind == K_GET);
                        rt_write  <= (dec.kind == K_SET);
                        inv_req   <= (dec.kind == K_INVAL);
                        fence_req <= (dec.kind == K_FENCE);
                        phase     <= PH_WAIT;
                    end
                end
                PH_WAIT: if (acked) begin
                    rt_req    <= 1'b0;
                    inv_req   <= 1'b0;
                    fence_req <= 1'b0;
                    busy      <= 1'b0;
                    status    <= ST_OK;
                    phase     <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r13_single_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rt_req, inv_req, fence_req}));

    a_r13_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        (rt_req | inv_req | fence_req) |-> busy);

    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (rt_req && !rt_ack) |=> rt_req);

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        (rt_req && rt_ack) |=> (!busy && status == ST_OK));

    a_r5_status_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (status != ST_NONE));
endmodule

// File: rtl/ckcmd_engine.sv
module ckcmd_engine
    import ckcmd_pkg::*;
#(
    parameter int NUM_RULES  = 8,
    parameter bit WIDE_MODES = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic [4:2]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic         rt_req,
    output logic         rt_write,
    output logic [15:0]  rt_idx,
    output logic [127:0] rt_wdata,
    input  logic [127:0] rt_rdata,
    input  logic         rt_ack,
    output logic         inv_req,
    output logic [7:0]   inv_dom,
    output logic         inv_dom_vld,
    output logic [43:0]  inv_ppn,
    output logic         inv_ppn_vld,
    output logic         inv_napot,
    input  logic         inv_ack,
    output logic         fence_req,
    input  logic         fence_ack
);
    localparam logic [2:0] W_CTRL_LO = 3'd2;
    localparam logic [2:0] W_OP0_LO  = 3'd4;

    cmd_t              cmd_q;
    logic [63:0]       op0_q, op1_q;
    logic              busy, load_ops, wr, start;
    st_e               status;
    decision_t         dec;
    logic [DOM_W-1:0]  dom;
    logic [PPN_W-1:0]  ppn;
    logic [MODE_W-1:0] mode;

    assign wr    = bus_sel & bus_we;
    assign start = wr && (bus_addr == W_CTRL_LO) && !busy;

    assign dom  = op0_q[DOM_LSB +: DOM_W];
    assign ppn  = op1_q[PPN_LSB +: PPN_W];
    assign mode = op1_q[MODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            op0_q <= '0;
            op1_q <= '0;
        end else if (load_ops) begin
            op0_q <= rt_rdata[63:0];
            op1_q <= rt_rdata[127:64];
        end else if (wr && !busy) begin
            case (bus_addr)
                3'd2: cmd_q         <= cmd_t'(bus_wdata[23:0]);
                3'd4: op0_q[31:0]   <= bus_wdata;
                3'd5: op0_q[63:32]  <= bus_wdata;
                3'd6: op1_q[31:0]   <= bus_wdata;
                3'd7: op1_q[63:32]  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            3'd0:    bus_rdata = {23'b0, WIDE_MODES, VERSION};
            3'd2:    bus_rdata = {8'b0, cmd_q};
            3'd3:    bus_rdata = {24'b0, busy, status};
            3'd4:    bus_rdata = op0_q[31:0];
            3'd5:    bus_rdata = op0_q[63:32];
            3'd6:    bus_rdata = op1_q[31:0];
            3'd7:    bus_rdata = op1_q[63:32];
            default: bus_rdata = '0;
        endcase
    end

    ckcmd_check #(.NUM_RULES(NUM_RULES)) u_check (
        .cmd (cmd_q),
        .dom (dom),
        .ppn (ppn),
        .mode(mode),
        .dec (dec)
    );

    ckcmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dec      (dec),
        .rt_ack   (rt_ack),
        .inv_ack  (inv_ack),
        .fence_ack(fence_ack),
        .busy     (busy),
        .status   (status),
        .rt_req   (rt_req),
        .rt_write (rt_write),
        .inv_req  (inv_req),
        .fence_req(fence_req),
        .load_ops (load_ops)
    );

    assign rt_idx      = cmd_q.idx;
    assign rt_wdata    = {op1_q, op0_q};
    assign inv_dom     = dom;
    assign inv_ppn     = ppn;
    assign inv_dom_vld = op1_q[DOMV_BIT];
    assign inv_ppn_vld = op1_q[PPNV_BIT];
    assign inv_napot   = op1_q[NAPOT_BIT];

    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    a_r12_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && wr && bus_addr == W_CTRL_LO) |=> (cmd_q == $past(cmd_q)));

    a_r12_op_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && wr && bus_addr == W_OP0_LO && !load_ops) |=> (op0_q[31:0] == $past(op0_q[31:0])));

    a_r7_no_bare_write: assert property (@(posedge clk) disable iff (rst)
        (rt_req && rt_write) |-> !(mode == '0 && (dom != '0 || ppn != '0)));

    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        rt_req |-> (rt_idx != '0 && rt_idx <= 16'(NUM_RULES)));
endmodule

// File: tb/test_ckcmd_engine.sv
module test_ckcmd_engine;
    localparam int NR = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:2]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         rt_req, rt_write;
    logic [15:0]  rt_idx;
    logic [127:0] rt_wdata;
    logic [127:0] rt_rdata = '0;
    logic         rt_ack = 1'b0, inv_ack = 1'b0, fence_ack = 1'b0;
    logic         inv_req, inv_dom_vld, inv_ppn_vld, inv_napot, fence_req;
    logic [7:0]   inv_dom;
    logic [43:0]  inv_ppn;

    int checks = 0;
    int errors = 0;
    int ack_delay = 2;

    always #4 clk = ~clk;

    ckcmd_engine #(.NUM_RULES(NR), .WIDE_MODES(1'b1)) i_ckcmd_engine (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rt_req(rt_req), .rt_write(rt_write), .rt_idx(rt_idx),
        .rt_wdata(rt_wdata), .rt_rdata(rt_rdata), .rt_ack(rt_ack),
        .inv_req(inv_req), .inv_dom(inv_dom), .inv_dom_vld(inv_dom_vld),
        .inv_ppn(inv_ppn), .inv_ppn_vld(inv_ppn_vld), .inv_napot(inv_napot),
        .inv_ack(inv_ack), .fence_req(fence_req), .fence_ack(fence_ack)
    );

    typedef struct {
        string        tag;
        int           kind;   // 1 set, 2 get, 3 inval, 4 fence
        logic [15:0]  idx;
        logic [127:0] data;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Rule-table / invalidation / fence responder with a bench-side table model
    logic [127:0] model [1:16];
    int cnt = 0;
    initial begin
        for (int i = 1; i <= 16; i++) model[i] = {64'hA5A5_0000_0000_0000 | 64'(i), 64'(i * 3)};
        forever begin
            @(negedge clk);
            if (rt_ack || inv_ack || fence_ack) begin
                rt_ack = 0; inv_ack = 0; fence_ack = 0; cnt = 0;
            end else if (rt_req || inv_req || fence_req) begin
                if (cnt >= ack_delay) begin
                    if (rt_req) begin
                        if (rt_write) model[rt_idx] = rt_wdata;
                        else rt_rdata = model[rt_idx];
                        rt_ack = 1;
                    end
                    if (inv_req) inv_ack = 1;
                    if (fence_req) fence_ack = 1;
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    // Monitor: every new downstream request is compared with the next expected item
    logic prev_any = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if ((rt_req || inv_req || fence_req) && !prev_any) begin
                int kind;
                logic [127:0] d;
                kind = rt_req ? (rt_write ? 1 : 2) : (inv_req ? 3 : 4);
                d = '0;
                if (kind == 1) d = rt_wdata;
                if (kind == 3) d = 128'({inv_dom, inv_dom_vld, inv_ppn, inv_ppn_vld, inv_napot});
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R13 unexpected request: actual kind=%0d expected none", kind);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " kind"}, 128'(kind), 128'(e.kind));
                    if (kind == 1 || kind == 2) chk({e.tag, " idx"}, 128'(rt_idx), 128'(e.idx));
                    if (kind == 1 || kind == 3) chk({e.tag, " data"}, d, e.data);
                end
            end
            prev_any = rt_req || inv_req || fence_req;
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ops(logic [63:0] o0, logic [63:0] o1);
        wr(3'd4, o0[31:0]); wr(3'd5, o0[63:32]);
        wr(3'd6, o1[31:0]); wr(3'd7, o1[63:32]);
    endtask

    task automatic cmd(logic [7:0] opc, logic [15:0] idx);
        wr(3'd2, {8'h0, idx, opc});
    endtask

    task automatic wait_idle(output logic [31:0] st);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            rd(3'd3, st);
            if (!st[7]) break;
        end
    endtask

    task automatic push(string tag, int kind, logic [15:0] idx, logic [127:0] data);
        exp_t e;
        e.tag = tag; e.kind = kind; e.idx = idx; e.data = data;
        exp_q.push_back(e);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] a0, a1;
        repeat (5) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(3'd3, r); chk("R1 busy/status after reset", r, 32'h0);
        // R2 capability word
        rd(3'd0, r); chk("R2 caps low", r, 32'h110);
        rd(3'd1, r); chk("R2 caps high", r, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, r); chk("R2 caps write ignored", r, 32'h110);

        // R3 operand readback
        set_ops(64'hDEAD_BEEF_0BAD_F00D, 64'h1357_9BDF_2468_ACE0);
        rd(3'd4, r); chk("R3 op0 lo", r, 32'h0BAD_F00D);
        rd(3'd5, r); chk("R3 op0 hi", r, 32'hDEAD_BEEF);
        rd(3'd6, r); chk("R3 op1 lo", r, 32'h2468_ACE0);
        rd(3'd7, r); chk("R3 op1 hi", r, 32'h1357_9BDF);

        // R4 / R11 fence with index 0
        push("R11 fence", 4, 16'h0, '0);
        cmd(8'd4, 16'h0);
        rd(3'd3, r); chk("R4 busy after command", r, 32'h80);
        rd(3'd2, r); chk("R4 command fields", r, 32'h0000_0004);
        wait_idle(r); chk("R11 fence status", r, 32'h01);

        // R5 invalid opcodes
        cmd(8'd0, 16'd1);
        rd(3'd3, r); chk("R5 busy set", r, 32'h81);
        @(negedge clk); rd(3'd3, r); chk("R5 opcode 0 status", r, 32'h02);
        cmd(8'd5, 16'd1); wait_idle(r); chk("R5 opcode 5 status", r, 32'h02);
        cmd(8'd200, 16'd1); wait_idle(r); chk("R5 opcode 200 status", r, 32'h02);

        // R6 rule index range
        set_ops(64'h0, 64'h9);
        cmd(8'd1, 16'd0); wait_idle(r); chk("R6 set index 0", r, 32'h03);
        cmd(8'd1, 16'd6); wait_idle(r); chk("R6 set index 6", r, 32'h03);
        cmd(8'd2, 16'd0); wait_idle(r); chk("R6 get index 0", r, 32'h03);
        cmd(8'd2, 16'hFFFF); wait_idle(r); chk("R6 get index ffff", r, 32'h03);

        // R7 bare-mode operand rules
        set_ops(64'h0000_0100_0000_0000, 64'h0);
        cmd(8'd1, 16'd1); wait_idle(r); chk("R7 bare with domain", r, 32'h04);
        set_ops(64'h0, 64'h400);
        cmd(8'd1, 16'd1); wait_idle(r); chk("R7 bare with page", r, 32'h04);
        a0 = 64'h0000_00FF_1234_5611; a1 = 64'h30;
        set_ops(a0, a1);
        push("R7 bare legal at index 5", 1, 16'd5, {a1, a0});
        cmd(8'd1, 16'd5); wait_idle(r); chk("R7 bare legal status", r, 32'h01);

        // R8 set rule
        a0 = 64'h0123_4567_89AB_CDEF; a1 = 64'h0000_0ABC_DEF0_1209;
        set_ops(a0, a1);
        push("R8 set rule", 1, 16'd3, {a1, a0});
        cmd(8'd1, 16'd3); wait_idle(r); chk("R8 set status", r, 32'h01);

        // R9 get rule returns stored record
        set_ops(64'h0, 64'h0);
        push("R9 get rule", 2, 16'd3, '0);
        cmd(8'd2, 16'd3); wait_idle(r); chk("R9 get status", r, 32'h01);
        rd(3'd4, r); chk("R9 op0 lo", r, a0[31:0]);
        rd(3'd5, r); chk("R9 op0 hi", r, a0[63:32]);
        rd(3'd6, r); chk("R9 op1 lo", r, a1[31:0]);
        rd(3'd7, r); chk("R9 op1 hi", r, a1[63:32]);
        push("R9 get untouched rule", 2, 16'd4, '0);
        cmd(8'd2, 16'd4); wait_idle(r);
        rd(3'd4, r); chk("R9 model op0 lo", r, 32'd12);

        // R10 invalidate ignores index
        set_ops(64'h0000_7700_0000_0000, 64'h48C30);
        push("R10 invalidate", 3, 16'h0, 128'({8'h77, 1'b0, 44'h123, 1'b1, 1'b1}));
        cmd(8'd3, 16'hFFFF); wait_idle(r); chk("R10 invalidate status", r, 32'h01);

        // R12 writes while busy are dropped
        ack_delay = 8;
        a0 = 64'h0000_0000_CAFE_0001; a1 = 64'h5;
        set_ops(a0, a1);
        push("R12 set during lock", 1, 16'd2, {a1, a0});
        cmd(8'd1, 16'd2);
        cmd(8'd4, 16'd1);
        wr(3'd4, 32'h1111_2222);
        wait_idle(r); chk("R12 status", r, 32'h01);
        rd(3'd2, r); chk("R12 command unchanged", r, 32'h0000_0201);
        rd(3'd4, r); chk("R12 operand unchanged", r, 32'hCAFE_0001);
        ack_delay = 2;

        // R4 high half of command is read-only
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, r); chk("R4 high half write ignored", r, 32'h01);

        repeat (10) @(negedge clk);
        chk("R13 all expected requests seen", 128'(exp_q.size()), 128'(0));
        summary();
        $finish;
    end
endmodule